// File: doc/BRIEF.md
# Second-Chance Page Replacement Manager

This block tracks which virtual pages occupy a fixed pool of physical page slots. The pool has two ordered parts. The active part holds recently faulted pages, which software may read and write freely. The second-chance part holds pages that are still resident but marked invalid, so any touch on them traps. Every access is looked up by virtual page number across both parts at the same time. A hit in the active part costs one cycle and changes nothing. Any other access is a fault.

On a fault the block rearranges the two parts. It reports whether the page was rescued from the second-chance part or must be paged in. When the pool is full it also names the page that has to leave. The active part behaves as a FIFO. The second-chance part is kept in strict recency order, and its oldest entry supplies the victim. Data movement, backing-store traffic and page tables belong to the surrounding system.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle. A request held with `req_valid` high while `req_ready` is low is not taken, and it must stay stable until a cycle in which both are high. The result and eviction outputs are one-cycle strobes with no back-pressure. A combinational probe port returns the state of any page.

Top module: `scl_page_manager`

## Requirements
- R1: After reset both parts are empty. `req_ready` is 1, `busy` is 0, `rsp_valid` and `evict_valid` are 0, and every probe returns 2'b00.
- R2: An access that hits the active part gives `rsp_valid` in the cycle after acceptance with `rsp_loc`=2'b01 and `rsp_pagein`=0. It raises no eviction and no `busy`, and it leaves the order of both parts unchanged.
- R3: An access that misses the active part is a fault. In the cycle after acceptance `busy` is 1, `req_ready` is 0 and `rsp_valid` is 0. The result appears one cycle later, with `busy` back at 0.
- R4: A fault on a page held in the second-chance part reports `rsp_loc`=2'b10 and `rsp_pagein`=0. It raises no eviction, and the page goes to the front of the active part with probe state 2'b01.
- R5: A fault on a page absent from both parts reports `rsp_loc`=2'b00 and `rsp_pagein`=1. The page goes to the front of the active part with probe state 2'b01.
- R6: When an insertion overfills the active part, its oldest page moves to the front of the second-chance part and its probe state becomes 2'b10.
- R7: A page-in on a full pool evicts the oldest page of the second-chance part. `evict_valid` is high for exactly one cycle, together with the result, with `evict_vpn` set to the victim. The victim then probes as 2'b00.
- R8: While the pool has free slots, a page-in takes a free slot and raises no eviction.
- R9: With a second-chance part of zero slots the block is a pure FIFO. The victim is the oldest active page, even if it was hit recently.
- R10: The probe returns 2'b01 for an active page, 2'b10 for a second-chance page and 2'b00 for an absent page, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_vpn | input | VPN_W | Virtual page number of the access |
| busy | output | 1 | Fault update in progress |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_loc | output | 2 | Where the page was found: 01 active, 10 second-chance, 00 none |
| rsp_pagein | output | 1 | Page must be loaded |
| rsp_vpn | output | VPN_W | Page number of the result |
| evict_valid | output | 1 | Victim strobe, one cycle |
| evict_vpn | output | VPN_W | Page number to evict |
| probe_vpn | input | VPN_W | Page number to query |
| probe_state | output | 2 | 01 read-write, 10 invalid, 00 absent |

## Verification
Several properties are checked on every cycle. A hit in the active part leaves both occupancy counts still. An accepted fault always raises `busy` on the next cycle. An eviction strobe never lasts two cycles and only goes with a page-in on a full active part. The faulting page always ends up at the front of the active part. Whether the victim is truly the least recently demoted page, and whether rescued pages and demoted pages land in the right order, can only be shown by the bench. It replays long random access streams against its own model of the two lists and probes page states after each access.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    LOC_NONE = 2'b00,
    LOC_ACT  = 2'b01,
    LOC_SC   = 2'b10
  } loc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_UPD  = 1'b1
  } mgr_state_e;
endpackage

// File: rtl/scl_match.sv
module scl_match #(
  parameter int N   = 4,
  parameter int W   = 8,
  parameter int IW  = (N > 1) ? $clog2(N) : 1,
  parameter int CW  = $clog2(N + 1)
) (
  input  logic [N-1:0][W-1:0] tags,
  input  logic [CW-1:0]       cnt,
  input  logic [W-1:0]        key,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit && (i < int'(cnt)) && (tags[i] == key)) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/scl_list_update.sv
module scl_list_update #(
  parameter int ACT  = 3,
  parameter int SC   = 2,
  parameter int W    = 8,
  parameter int SCD  = (SC > 0) ? SC : 1,
  parameter int AW   = $clog2(ACT + 1),
  parameter int SW   = $clog2(SCD + 1),
  parameter int SIW  = (SCD > 1) ? $clog2(SCD) : 1
) (
  input  logic [ACT-1:0][W-1:0] act,
  input  logic [AW-1:0]         act_cnt,
  input  logic [SCD-1:0][W-1:0] sc,
  input  logic [SW-1:0]         sc_cnt,
  input  logic [W-1:0]          ins_vpn,
  input  logic                  from_sc,
  input  logic [SIW-1:0]        sc_idx,
  output logic [ACT-1:0][W-1:0] n_act,
  output logic [AW-1:0]         n_act_cnt,
  output logic [SCD-1:0][W-1:0] n_sc,
  output logic [SW-1:0]         n_sc_cnt,
  output logic                  evict,
  output logic [W-1:0]          evict_vpn
);
  logic ovf;
  logic pool_full;

  assign ovf       = (act_cnt == AW'(ACT));
  assign pool_full = ovf && (sc_cnt == SW'(SC));
  assign evict     = !from_sc && pool_full;

  always_comb begin
    n_act[0] = ins_vpn;
    for (int i = 1; i < ACT; i++) n_act[i] = act[i-1];
    n_act_cnt = ovf ? act_cnt : act_cnt + AW'(1);
  end

  generate
    if (SC == 0) begin : g_fifo
      assign evict_vpn = act[ACT-1];
      assign n_sc      = '0;
      assign n_sc_cnt  = '0;
    end else begin : g_two_list
      logic [SCD-1:0][W-1:0] rem;
      logic [SW-1:0]         rem_cnt;

      assign evict_vpn = sc[SCD-1];

      always_comb begin
        for (int i = 0; i < SCD; i++) begin
          if (from_sc && (i >= int'(sc_idx)))
            rem[i] = (i + 1 < SCD) ? sc[(i + 1 < SCD) ? i + 1 : i] : '0;
          else
            rem[i] = sc[i];
        end
        rem_cnt = (from_sc || evict) ? sc_cnt - SW'(1) : sc_cnt;
        if (ovf) begin
          n_sc[0] = act[ACT-1];
          for (int i = 1; i < SCD; i++) n_sc[i] = rem[i-1];
          n_sc_cnt = rem_cnt + SW'(1);
        end else begin
          n_sc     = rem;
          n_sc_cnt = rem_cnt;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/scl_page_manager.sv
module scl_page_manager
  import scl_pkg::*;
#(
  parameter int VPN_W     = 8,
  parameter int ACT_SLOTS = 3,
  parameter int SC_SLOTS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             busy,
  output logic             rsp_valid,
  output logic [1:0]       rsp_loc,
  output logic             rsp_pagein,
  output logic [VPN_W-1:0] rsp_vpn,
  output logic             evict_valid,
  output logic [VPN_W-1:0] evict_vpn,
  input  logic [VPN_W-1:0] probe_vpn,
  output logic [1:0]       probe_state
);
  localparam int SCD = (SC_SLOTS > 0) ? SC_SLOTS : 1;
  localparam int AW  = $clog2(ACT_SLOTS + 1);
  localparam int SW  = $clog2(SCD + 1);
  localparam int AIW = (ACT_SLOTS > 1) ? $clog2(ACT_SLOTS) : 1;
  localparam int SIW = (SCD > 1) ? $clog2(SCD) : 1;

  mgr_state_e                   state;
  logic [ACT_SLOTS-1:0][VPN_W-1:0] act_q;
  logic [SCD-1:0][VPN_W-1:0]    sc_q;
  logic [AW-1:0]                act_cnt;
  logic [SW-1:0]                sc_cnt;
  logic [VPN_W-1:0]             lat_vpn;
  logic                         lat_from_sc;
  logic [SIW-1:0]               lat_idx;

  logic                  act_hit, sc_hit, prb_act, prb_sc;
  logic [AIW-1:0]        act_idx, prb_act_idx;
  logic [SIW-1:0]        sc_idx, prb_sc_idx;

  logic [ACT_SLOTS-1:0][VPN_W-1:0] n_act;
  logic [AW-1:0]                   n_act_cnt;
  logic [SCD-1:0][VPN_W-1:0]       n_sc;
  logic [SW-1:0]                   n_sc_cnt;
  logic                            upd_evict;
  logic [VPN_W-1:0]                upd_evict_vpn;

  scl_match #(.N(ACT_SLOTS), .W(VPN_W)) u_req_act (
    .tags(act_q), .cnt(act_cnt), .key(req_vpn), .hit(act_hit), .idx(act_idx));
  scl_match #(.N(SCD), .W(VPN_W)) u_req_sc (
    .tags(sc_q), .cnt(sc_cnt), .key(req_vpn), .hit(sc_hit), .idx(sc_idx));
  scl_match #(.N(ACT_SLOTS), .W(VPN_W)) u_prb_act (
    .tags(act_q), .cnt(act_cnt), .key(probe_vpn), .hit(prb_act), .idx(prb_act_idx));
  scl_match #(.N(SCD), .W(VPN_W)) u_prb_sc (
    .tags(sc_q), .cnt(sc_cnt), .key(probe_vpn), .hit(prb_sc), .idx(prb_sc_idx));

  scl_list_update #(.ACT(ACT_SLOTS), .SC(SC_SLOTS), .W(VPN_W)) u_upd (
    .act(act_q), .act_cnt(act_cnt), .sc(sc_q), .sc_cnt(sc_cnt),
    .ins_vpn(lat_vpn), .from_sc(lat_from_sc), .sc_idx(lat_idx),
    .n_act(n_act), .n_act_cnt(n_act_cnt), .n_sc(n_sc), .n_sc_cnt(n_sc_cnt),
    .evict(upd_evict), .evict_vpn(upd_evict_vpn));

  assign req_ready   = (state == ST_IDLE);
  assign busy        = (state == ST_UPD);
  assign probe_state = prb_act ? LOC_ACT : (prb_sc ? LOC_SC : LOC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      act_q       <= '0;
      sc_q        <= '0;
      act_cnt     <= '0;
      sc_cnt      <= '0;
      lat_vpn     <= '0;
      lat_from_sc <= 1'b0;
      lat_idx     <= '0;
      rsp_valid   <= 1'b0;
      rsp_loc     <= LOC_NONE;
      rsp_pagein  <= 1'b0;
      rsp_vpn     <= '0;
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      evict_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            lat_vpn <= req_vpn;
            rsp_vpn <= req_vpn;
            if (act_hit) begin
              rsp_valid  <= 1'b1;
              rsp_loc    <= LOC_ACT;
              rsp_pagein <= 1'b0;
            end else begin
              state       <= ST_UPD;
              lat_from_sc <= sc_hit;
              lat_idx     <= sc_idx;
            end
          end
        end
        ST_UPD: begin
          act_q       <= n_act;
          act_cnt     <= n_act_cnt;
          sc_q        <= n_sc;
          sc_cnt      <= n_sc_cnt;
          rsp_valid   <= 1'b1;
          rsp_loc     <= lat_from_sc ? LOC_SC : LOC_NONE;
          rsp_pagein  <= !lat_from_sc;
          evict_valid <= upd_evict;
          evict_vpn   <= upd_evict_vpn;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  act_hit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && act_hit) |=> ($stable(act_cnt) && $stable(sc_cnt) && !busy));

  // R3
  fault_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !act_hit) |=> (busy && !req_ready && !rsp_valid));

  // R7
  evict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> !evict_valid);

  // R8
  evict_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (rsp_pagein && rsp_valid && act_cnt == AW'(ACT_SLOTS)));

  // R5
  front_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (act_q[0] == $past(lat_vpn) && act_cnt != '0));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cnt <= AW'(ACT_SLOTS)) && (sc_cnt <= SW'(SC_SLOTS)));
endmodule

// File: tb/tb_scl_page_manager.sv
`timescale 1ns/1ps
module tb_scl_page_manager;
  localparam int W   = 8;
  localparam int ACT = 3;
  localparam int SC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         req_valid = 1'b0, req_ready, busy, rsp_valid, rsp_pagein, evict_valid;
  logic [W-1:0] req_vpn = '0, rsp_vpn, evict_vpn, probe_vpn = '0;
  logic [1:0]   rsp_loc, probe_state;

  logic         f_req_valid = 1'b0, f_req_ready, f_busy, f_rsp_valid, f_rsp_pagein, f_evict_valid;
  logic [W-1:0] f_req_vpn = '0, f_rsp_vpn, f_evict_vpn;
  logic [1:0]   f_rsp_loc, f_probe_state;

  scl_page_manager #(.VPN_W(W), .ACT_SLOTS(ACT), .SC_SLOTS(SC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .busy(busy), .rsp_valid(rsp_valid), .rsp_loc(rsp_loc),
    .rsp_pagein(rsp_pagein), .rsp_vpn(rsp_vpn), .evict_valid(evict_valid),
    .evict_vpn(evict_vpn), .probe_vpn(probe_vpn), .probe_state(probe_state));

  scl_page_manager #(.VPN_W(W), .ACT_SLOTS(2), .SC_SLOTS(0)) dut_fifo (
    .clk(clk), .rst_n(rst_n), .req_valid(f_req_valid), .req_ready(f_req_ready),
    .req_vpn(f_req_vpn), .busy(f_busy), .rsp_valid(f_rsp_valid), .rsp_loc(f_rsp_loc),
    .rsp_pagein(f_rsp_pagein), .rsp_vpn(f_rsp_vpn), .evict_valid(f_evict_valid),
    .evict_vpn(f_evict_vpn), .probe_vpn(8'd0), .probe_state(f_probe_state));

  int n_tests = 0;
  int n_fail  = 0;
  int mact[$];
  int msc[$];

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int model_state(input int v);
    foreach (mact[i]) if (mact[i] == v) return 1;
    foreach (msc[i]) if (msc[i] == v) return 2;
    return 0;
  endfunction

  // reference model: returns loc, page-in, eviction and victim
  task automatic model_step(input int v, output int loc, output bit pin,
                            output bit ev, output int evv);
    int k;
    loc = 0; pin = 0; ev = 0; evv = 0; k = -1;
    foreach (mact[i]) if (mact[i] == v) loc = 1;
    if (loc == 1) return;
    foreach (msc[i]) if (msc[i] == v) k = i;
    if (k >= 0) begin
      loc = 2;
      msc.delete(k);
    end else begin
      pin = 1;
      if (mact.size() + msc.size() == ACT + SC) begin
        ev = 1;
        evv = msc[$];
        void'(msc.pop_back());
      end
    end
    mact.push_front(v);
    if (mact.size() > ACT) msc.push_front(mact.pop_back());
  endtask

  task automatic probe(input int v, input string req);
    probe_vpn = W'(v);
    #1;
    check(probe_state == 2'(model_state(v)), req, probe_state, model_state(v));
  endtask

  task automatic access(input int v, input string tag);
    int eloc, evv;
    bit epin, eev;
    model_step(v, eloc, epin, eev, evv);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = W'(v);
    @(negedge clk);
    req_valid = 1'b0;
    if (eloc == 1) begin
      check(rsp_valid && !busy && rsp_loc == 2'b01 && !rsp_pagein && !evict_valid,
            {"R2 active hit ", tag}, rsp_loc, 1);
    end else begin
      check(busy && !req_ready && !rsp_valid, {"R3 fault busy ", tag}, busy, 1);
      @(negedge clk);
      check(rsp_valid && !busy && rsp_loc == 2'(eloc) && rsp_pagein == epin,
            (eloc == 2) ? {"R4 sc rescue ", tag} : {"R5 page-in ", tag}, rsp_loc, eloc);
      check(evict_valid == eev, eev ? {"R7 evict strobe ", tag} : {"R8 no evict ", tag},
            evict_valid, eev);
      if (eev) check(evict_vpn == W'(evv), {"R7 victim ", tag}, evict_vpn, evv);
    end
    check(rsp_vpn == W'(v), {"R2 rsp vpn ", tag}, rsp_vpn, v);
    @(negedge clk);
    check(!evict_valid && !rsp_valid, {"R7 one-cycle strobe ", tag}, evict_valid, 0);
  endtask

  task automatic f_access(input int v, input bit ehit, input bit eev, input int evv);
    @(negedge clk);
    while (!f_req_ready) @(negedge clk);
    f_req_valid = 1'b1;
    f_req_vpn   = W'(v);
    @(negedge clk);
    f_req_valid = 1'b0;
    if (!ehit) @(negedge clk);
    check(f_rsp_valid && f_rsp_pagein == !ehit, "R9 fifo result", f_rsp_pagein, !ehit);
    check(f_evict_valid == eev, "R9 fifo evict", f_evict_valid, eev);
    if (eev) check(f_evict_vpn == W'(evv), "R9 fifo victim", f_evict_vpn, evv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !busy && !rsp_valid && !evict_valid, "R1 reset outputs", req_ready, 1);
    probe(1, "R1 empty probe");

    // directed fill: no eviction while free slots (R8)
    access(1, "fill1"); probe(1, "R10 active state");
    access(2, "fill2");
    access(3, "fill3");
    access(4, "fill4"); probe(1, "R6 demoted invalid");
    access(5, "fill5"); probe(2, "R6 demoted invalid");
    access(3, "hit3");  probe(3, "R2 unchanged");
    access(1, "rescue1"); probe(1, "R4 rescued read-write"); probe(3, "R6 overflow");
    access(6, "full6"); probe(2, "R7 victim absent"); probe(4, "R10 sc state");
    access(7, "full7");

    // constrained random stream over a small page space
    for (int n = 0; n < 400; n++) begin
      access(1 + int'($urandom_range(0, 8)), "rand");
      probe(1 + int'($urandom_range(0, 9)), "R10 random probe");
    end

    // FIFO degenerate configuration (R9)
    f_access(1, 0, 0, 0);
    f_access(2, 0, 0, 0);
    f_access(3, 0, 1, 1);
    f_access(2, 1, 0, 0);
    f_access(4, 0, 1, 2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule